// File: doc/BRIEF.md
# Even Step Pulse Spreader

This block spreads a requested number of step pulses (the rate, Y) as evenly as it can over a window of tick periods (the length, X). Each output channel keeps its own error accumulator. A shared tick-enable input advances all channels together. Only integer additions, subtractions and comparisons are used. Every window starts with its error term at one half, so each pattern is centred and symmetric. Windows follow one another with no gap, so a steady setting gives a pattern that repeats every X ticks.

A host writes the window length and the rates through a small write-only register port. The values written go into shadow registers. The block copies them into its working registers only at the first tick of a window, so a window never mixes two settings. The working registers hold the doubled constants. Each channel raises a one-cycle step strobe, and a shared flag marks the last tick of each window.

Top module: `step_spread`

## Requirements
- R1: During reset and after it, every `step` bit and `wend` are 0, all shadow and working values are 0, and the tick counter is at window start.
- R2: At the first tick of a window, a channel's accumulator is loaded with X. On every tick the accumulator gains 2Y. When the sum is at least 2X, the channel steps and 2X is subtracted. With X=10 and Y=5 the channel steps on ticks 1, 3, 5, 7 and 9 of each window.
- R3: Y=0 gives no step in the window. Y=X gives a step on every tick.
- R4: A rate larger than the window length is clamped to the window length when it is latched, so the channel steps on every tick.
- R5: A tick in clock cycle n produces its `step` and `wend` values in cycle n+1. These outputs stay high for exactly one cycle and are 0 in any cycle that does not follow a tick.
- R6: A window is X ticks long. `wend` is high for the X-th tick of each window, and the next tick begins a new window straight away.
- R7: Register writes land in shadow registers. Address 0 holds X, and address k+1 holds Y for channel k. A shadow value is used only from the next window's first tick; writes made during a window leave the rest of that window unchanged.
- R8: The channels are independent. In each complete window, channel k steps exactly min(Yk, X) times.
- R9: While the latched window length is 0, ticks produce no step and no `wend`, and every tick is a window start, so a new nonzero X takes effect on the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Tick enable, one clock cycle per period |
| cfg_we | input | 1 | Write strobe for the shadow registers |
| cfg_addr | input | $clog2(NCH+1) | 0 selects X; k+1 selects Y of channel k |
| cfg_data | input | XW | Value written |
| step | output | NCH | Per-channel step strobe |
| wend | output | 1 | Strobe for the last tick of a window |

## Verification
The assertions assume two things about the inputs: `tick` is a clean single-cycle enable, and the host never writes in the same cycle as a window-start tick. If a write and a start tick share a cycle, the old shadow value is latched, and the overflow and idle properties would reason about a value that changed under them. The stimulus writes only in cycles without a tick. Mid-window updates fall between ticks. Tick streams are either back-to-back or spaced by idle cycles, and neither kind moves a window boundary.

// File: rtl/step_spread.sv
module step_spread #(
  parameter int NCH = 4,
  parameter int XW  = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tick,
  input  logic                       cfg_we,
  input  logic [$clog2(NCH+1)-1:0]   cfg_addr,
  input  logic [XW-1:0]              cfg_data,
  output logic [NCH-1:0]             step,
  output logic                       wend
);
  localparam int AW = $clog2(NCH+1);
  localparam int DW = XW + 1;
  localparam int CW = XW + 2;
  localparam logic [XW:0] ONE = 1;

  logic [XW-1:0]                x_sh;
  logic [NCH-1:0][XW-1:0]       y_sh;
  logic [DW-1:0]                dx_q;
  logic [NCH-1:0][DW-1:0]       dy_q;
  logic [NCH-1:0][CW-1:0]       acc_q;
  logic [XW-1:0]                cnt_q;
  logic [NCH-1:0]               step_q;
  logic                         wend_q;

  logic              at_start, last;
  logic [DW-1:0]     dx_use;
  logic [NCH-1:0]    hit;

  assign at_start = (cnt_q == '0);
  assign dx_use   = at_start ? {x_sh, 1'b0} : dx_q;
  assign last     = (dx_use != '0) && (({1'b0, cnt_q} + ONE) == {1'b0, dx_use[DW-1:1]});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_sh <= '0;
    end else if (cfg_we && cfg_addr == '0) begin
      x_sh <= cfg_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dx_q   <= '0;
      cnt_q  <= '0;
      wend_q <= 1'b0;
    end else begin
      wend_q <= tick & last;
      if (tick) begin
        if (at_start) dx_q <= dx_use;
        cnt_q <= (last || dx_use == '0) ? '0 : cnt_q + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [XW-1:0] y_cl;
    logic [DW-1:0] dy_use;
    logic [CW-1:0] acc_in, sum, acc_nx;

    assign y_cl   = (y_sh[g] > x_sh) ? x_sh : y_sh[g];
    assign dy_use = at_start ? {y_cl, 1'b0} : dy_q[g];
    assign acc_in = at_start ? {2'b00, dx_use[DW-1:1]} : acc_q[g];
    assign sum    = acc_in + {1'b0, dy_use};
    assign hit[g] = (dx_use != '0) && (sum >= {1'b0, dx_use});
    assign acc_nx = hit[g] ? sum - {1'b0, dx_use} : sum;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        y_sh[g] <= '0;
      end else if (cfg_we && cfg_addr == AW'(g + 1)) begin
        y_sh[g] <= cfg_data;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        dy_q[g]   <= '0;
        acc_q[g]  <= '0;
        step_q[g] <= 1'b0;
      end else begin
        step_q[g] <= tick & hit[g];
        if (tick) begin
          acc_q[g] <= acc_nx;
          if (at_start) dy_q[g] <= dy_use;
        end
      end
    end
  end

  assign step = step_q;
  assign wend = wend_q;
endmodule

module step_spread_chk #(
  parameter int NCH = 4,
  parameter int XW  = 16
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         tick,
  input logic [NCH-1:0]               step,
  input logic                         wend,
  input logic [NCH-1:0][XW+1:0]       acc_q,
  input logic [XW:0]                  dx_q,
  input logic [XW-1:0]                x_sh,
  input logic [XW-1:0]                cnt_q
);
  AST_STEP_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (step != '0) |-> $past(tick)); // R5
  AST_QUIET_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> (step == '0 && !wend)); // R5
  AST_WEND_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    wend |-> $past(tick)); // R6
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_q == '0 && x_sh == '0) |=> (step == '0 && !wend)); // R9

  for (genvar g = 0; g < NCH; g++) begin : g_a
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_q[g] < {1'b0, dx_q}) || (dx_q == '0 && acc_q[g] == '0)); // R2
  end
endmodule

bind step_spread step_spread_chk #(.NCH(NCH), .XW(XW)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick(tick), .step(step), .wend(wend),
  .acc_q(acc_q), .dx_q(dx_q), .x_sh(x_sh), .cnt_q(cnt_q)
);

// File: tb/step_spread_tb.sv
`timescale 1ns/1ps
module step_spread_tb_top;
  localparam int NCH = 4;
  localparam int XW  = 16;
  localparam int AW  = $clog2(NCH+1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic cfg_we = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [XW-1:0] cfg_data = '0;
  logic [NCH-1:0] step;
  logic wend;

  always #2 clk = ~clk;

  step_spread #(.NCH(NCH), .XW(XW)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data), .step(step), .wend(wend)
  );

  typedef struct {
    logic [NCH-1:0] st;
    logic           we;
    string          tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  string cur_tag = "R1";
  int obs[NCH];
  logic tick_d = 1'b0;

  int m_sx, m_dx, m_cnt;
  int m_sy[NCH];
  int m_dy[NCH];
  int m_acc[NCH];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) tick_d <= tick;

  always @(negedge clk) begin
    if (rst_n) begin
      if (tick_d) begin
        exp_t e;
        if (q.size() == 0) begin
          chk(1'b0, "R5 queue", 1, 0);
        end else begin
          e = q.pop_front();
          chk(step == e.st, e.tag, step, e.st);
          chk(wend == e.we, {e.tag, " R6 wend"}, wend, e.we);
        end
        for (int k = 0; k < NCH; k++) if (step[k]) obs[k]++;
      end else begin
        chk(step == '0 && !wend, "R5 idle cycle", {wend, step}, 0);
      end
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = AW'(a); cfg_data = XW'(d);
    if (a == 0) m_sx = d; else m_sy[a-1] = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_tick();
    exp_t e;
    bit start;
    int x, sum;
    start = (m_cnt == 0);
    if (start) m_dx = 2 * m_sx;
    x = m_dx / 2;
    e.st = '0;
    e.tag = cur_tag;
    for (int k = 0; k < NCH; k++) begin
      if (start) begin
        m_dy[k] = 2 * ((m_sy[k] > m_sx) ? m_sx : m_sy[k]);
        m_acc[k] = x;
      end
      sum = m_acc[k] + m_dy[k];
      if (m_dx != 0 && sum >= m_dx) begin
        e.st[k] = 1'b1;
        sum -= m_dx;
      end
      m_acc[k] = sum;
    end
    e.we = (m_dx != 0) && (m_cnt + 1 == x);
    m_cnt = (e.we || m_dx == 0) ? 0 : m_cnt + 1;
    q.push_back(e);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic run(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      do_tick();
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic settle();
    @(negedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic clr_obs();
    for (int k = 0; k < NCH; k++) obs[k] = 0;
  endtask

  initial begin
    #600000;
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    m_sx = 0; m_dx = 0; m_cnt = 0;
    for (int k = 0; k < NCH; k++) begin
      m_sy[k] = 0; m_dy[k] = 0; m_acc[k] = 0;
    end
    clr_obs();
    repeat (3) @(negedge clk);
    chk(step == '0 && !wend, "R1 outputs in reset", {wend, step}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(step == '0 && !wend, "R1 outputs after reset", {wend, step}, 0);

    cur_tag = "R9 idle with X=0";
    run(5, 0);
    settle();

    // R2 R3 R8: X=10, Y = 5, 0, 10, 3
    wr(0, 10); wr(1, 5); wr(2, 0); wr(3, 10); wr(4, 3);
    cur_tag = "R2 R3 pattern";
    clr_obs();
    run(10, 0);
    settle();
    chk(obs[0] == 5, "R2 Y=5 count", obs[0], 5);
    chk(obs[1] == 0, "R3 Y=0 count", obs[1], 0);
    chk(obs[2] == 10, "R3 Y=X count", obs[2], 10);
    chk(obs[3] == 3, "R8 Y=3 count", obs[3], 3);
    cur_tag = "R6 continuous repeat";
    clr_obs();
    run(10, 0);
    settle();
    chk(obs[0] == 5 && obs[3] == 3, "R6 second window", obs[0] * 100 + obs[3], 503);

    // R7: mid-window writes, R4 clamp
    cur_tag = "R7 old window";
    clr_obs();
    run(4, 0);
    wr(0, 7); wr(1, 7); wr(2, 200); wr(4, 2);
    run(6, 1);
    settle();
    chk(obs[0] == 5 && obs[1] == 0 && obs[3] == 3, "R7 old rates kept",
        obs[0] * 10000 + obs[1] * 100 + obs[3], 50003);
    cur_tag = "R4 R7 new window";
    clr_obs();
    run(7, 2);
    settle();
    chk(obs[1] == 7, "R4 clamped rate", obs[1], 7);
    chk(obs[3] == 2 && obs[2] == 7, "R8 new counts", obs[3] * 100 + obs[2], 207);

    // boundary: X=1 and X=3
    wr(0, 1); wr(1, 1); wr(2, 0); wr(3, 1); wr(4, 5);
    cur_tag = "R6 X=1";
    clr_obs();
    run(7, 0);
    settle();
    chk(obs[0] == 7 && obs[1] == 0 && obs[3] == 7, "R6 X=1 counts",
        obs[0] * 10000 + obs[1] * 100 + obs[3], 70007);
    wr(0, 3); wr(1, 2); wr(2, 1);
    cur_tag = "R2 X=3";
    clr_obs();
    run(6, 0);
    settle();
    chk(obs[0] == 4 && obs[1] == 2, "R8 X=3 counts", obs[0] * 100 + obs[1], 402);

    // back to idle
    wr(0, 0);
    cur_tag = "R9 return to idle";
    clr_obs();
    run(8, 1);
    settle();
    chk(obs[0] == 0 && obs[3] == 0, "R9 no steps", obs[0] + obs[3], 0);
    chk(q.size() == 0, "R5 all ticks answered", q.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule